// File: doc/BRIEF.md
# Peripheral control register with clock-crossing enable

This block is the main control register of a peripheral. Its bus side uses a single write strobe and a continuously driven read word. The peripheral side lives in a separate clock domain. The register holds a set of configuration fields, an enable bit and a self-clearing software-reset bit.

The configuration fields drive the peripheral straight from the bus domain. This is safe because they can only change while the peripheral is disabled. The enable bit and the software-reset command reach the peripheral clock domain through one toggle handshake that carries a two-bit command. Software sees the enable bit it wrote at once. A busy flag shows when that value has not yet taken effect on the peripheral side.

A software reset clears the register at once and then sends a reset command across the handshake. The peripheral side answers with a one-cycle reset pulse, which it uses to clear its own state, and drops its enable. The reset bit reads as 1 until the command has been acknowledged. No write is accepted during that time.

Top module: `ctrl_reg_xdom`

## Requirements
- R1: After reset the read word, the busy flag, the configuration output, the peripheral enable and the peripheral reset pulse are all zero.
- R2: The read word layout is: bit 0 software reset, bit 1 enable, bits 22:4 configuration (bits 6:4 divider select, 8:7 counter width, 10:9 wrap sync, 11 standby run, 12 clock on demand, 13 auto lock, 14 single DMA trigger, 16:15 capture enable, 18:17 capture from pin, 20:19 capture mode 0, 22:21 capture mode 1). All other bits read 0. A write with bit 0 clear, made while the enable bit reads 0, stores bits 22:4 in the cycle after the write strobe.
- R3: While the enable bit reads 1, a write leaves bits 22:4 unchanged. This includes a write that clears the enable.
- R4: A write with bit 0 clear makes the enable bit read back the written bit 1 in the cycle after the strobe.
- R5: Every accepted write with bit 0 clear raises the busy flag in the next cycle. With the default two-flop synchronizers, an isolated write changes the peripheral enable 4 cycles after the write edge and drops the busy flag 7 cycles after it.
- R6: A write with bit 0 set clears bits 22:1 in the next cycle, discards every other bit of that write, and makes bit 0 read 1.
- R7: Bit 0 reads 1 until the reset command has been acknowledged across the crossing, then it clears on its own.
- R8: A reset command arriving on the peripheral side produces a single-cycle reset pulse and clears the peripheral enable in the same cycle.
- R9: Writes made while bit 0 reads 1 are ignored.
- R10: An enable write made while a transfer is in flight is delivered after that transfer completes. The busy flag stays high throughout, and the final peripheral enable equals the last value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Register (bus) clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register contents |
| en_busy | output | 1 | Enable change not yet completed in the peripheral domain |
| cfg_o | output | 19 | Configuration fields to the peripheral |
| per_clk | input | 1 | Peripheral clock |
| per_rst | input | 1 | Synchronous active-high reset, peripheral domain |
| per_en | output | 1 | Enable in the peripheral clock domain |
| per_srst | output | 1 | One-cycle reset pulse in the peripheral domain |

## Verification
The embedded assertions check the following on every cycle:
- protected fields stay frozen while enabled;
- the enable read-back follows each write;
- the register is cleared and locked while a software reset is pending;
- the command stays stable while in flight;
- the busy flag rises after each enable write;
- the peripheral reset pulse is a single cycle and coincides with a cleared enable.

Only the bench scenarios can show the following:
- the exact crossing latencies;
- the queuing of a second enable write behind an in-flight one;
- the ordering of a reset behind a pending enable transfer;
- the full read-word layout.

These are compared against a behavioural model on every clock.

// File: rtl/ctrl_reg_pkg.sv
package ctrl_reg_pkg;

    localparam int REG_W     = 32;
    localparam int CFG_LSB   = 4;
    localparam int SRST_BIT  = 0;
    localparam int EN_BIT    = 1;

    // Configuration fields, most significant first (bits 22:4 of the word).
    typedef struct packed {
        logic [1:0] cap_mode1;
        logic [1:0] cap_mode0;
        logic [1:0] cap_pin;
        logic [1:0] cap_en;
        logic       dma_single;
        logic       auto_lock;
        logic       clk_ondemand;
        logic       stby_run;
        logic [1:0] wrap_sync;
        logic [1:0] cnt_width;
        logic [2:0] div_sel;
    } cfg_t;

    localparam int CFG_W   = $bits(cfg_t);
    localparam int CFG_MSB = CFG_LSB + CFG_W - 1;
    localparam int PAD_HI  = REG_W - CFG_MSB - 1;
    localparam int PAD_LO  = CFG_LSB - 2;

    // Command carried across the clock crossing.
    typedef struct packed {
        logic srst;
        logic en;
    } xcmd_t;

    function automatic cfg_t cfg_of_word(input logic [REG_W-1:0] w);
        return cfg_t'(w[CFG_MSB:CFG_LSB]);
    endfunction

    function automatic logic [REG_W-1:0] word_of(input cfg_t c, input logic en,
                                                 input logic srst);
        return {{PAD_HI{1'b0}}, c, {PAD_LO{1'b0}}, en, srst};
    endfunction

endpackage

// File: rtl/ctrl_sync.sv
module ctrl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ctrl_reg_file.sv
module ctrl_reg_file
    import ctrl_reg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             srst_done,
    output cfg_t             cfg,
    output logic             en,
    output logic             srst_pend,
    output logic             en_wr,
    output logic             srst_wr
);
    logic accept;
    logic unused_bits;

    assign accept      = wr_en && !srst_pend;
    assign srst_wr     = accept && wr_data[SRST_BIT];
    assign en_wr       = accept && !wr_data[SRST_BIT];
    assign unused_bits = ^{wr_data[REG_W-1:CFG_MSB+1], wr_data[CFG_LSB-1:EN_BIT+1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            en        <= 1'b0;
            srst_pend <= 1'b0;
        end else if (srst_wr) begin
            // Reset wins over every other field of the same write.
            cfg       <= '0;
            en        <= 1'b0;
            srst_pend <= 1'b1;
        end else begin
            if (en_wr) begin
                en <= wr_data[EN_BIT];
                if (!en) cfg <= cfg_of_word(wr_data);
            end
            if (srst_done) srst_pend <= 1'b0;
        end
    end

    // R3: protected fields frozen while enabled
    a_r3_protect: assert property (@(posedge clk) disable iff (rst)
        (wr_en && en && !srst_pend && !wr_data[SRST_BIT]) |=> $stable(cfg));

    // R4: enable reads back what was written
    a_r4_readback: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !srst_pend && !wr_data[SRST_BIT]) |=> (en == $past(wr_data[EN_BIT])));

    // R6: reset write clears all fields
    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !srst_pend && wr_data[SRST_BIT]) |=> (srst_pend && cfg == '0 && !en));

    // R9: register stays cleared while reset pending
    a_r9_locked: assert property (@(posedge clk) disable iff (rst)
        srst_pend |-> (cfg == '0 && !en));
endmodule

// File: rtl/ctrl_xfer_src.sv
module ctrl_xfer_src
    import ctrl_reg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  en_wr,
    input  logic  srst_wr,
    input  logic  en_val,
    input  logic  ack_tgl,
    output logic  req_tgl,
    output xcmd_t cmd,
    output logic  en_busy,
    output logic  srst_done
);
    logic srst_q, dirty, inflight;
    logic ack_s, ack_q, ack_edge;

    ctrl_sync #(.STAGES(SYNC_STAGES)) i_ack_sync (
        .clk (clk),
        .rst (rst),
        .d   (ack_tgl),
        .q   (ack_s)
    );

    assign ack_edge  = ack_s ^ ack_q;
    assign srst_done = inflight && ack_edge && cmd.srst;
    assign en_busy   = dirty || (inflight && !cmd.srst);

    always_ff @(posedge clk) begin
        if (rst) begin
            srst_q   <= 1'b0;
            dirty    <= 1'b0;
            inflight <= 1'b0;
            req_tgl  <= 1'b0;
            ack_q    <= 1'b0;
            cmd      <= '0;
        end else begin
            ack_q <= ack_s;
            if (inflight) begin
                if (ack_edge) inflight <= 1'b0;
            end else if (srst_q) begin
                cmd      <= '{srst: 1'b1, en: 1'b0};
                req_tgl  <= ~req_tgl;
                inflight <= 1'b1;
                srst_q   <= 1'b0;
            end else if (dirty) begin
                cmd      <= '{srst: 1'b0, en: en_val};
                req_tgl  <= ~req_tgl;
                inflight <= 1'b1;
                dirty    <= 1'b0;
            end
            // New writes come last so they override the launch bookkeeping.
            if (srst_wr) begin
                srst_q <= 1'b1;
                dirty  <= 1'b0;
            end else if (en_wr) begin
                dirty <= 1'b1;
            end
        end
    end

    // R10: command held stable while a transfer is in flight
    a_r10_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        (inflight && !ack_edge) |=> $stable(cmd));

    // R5: busy raised after each accepted enable write
    a_r5_busy_set: assert property (@(posedge clk) disable iff (rst)
        en_wr |=> en_busy);
endmodule

// File: rtl/ctrl_xfer_dst.sv
module ctrl_xfer_dst
    import ctrl_reg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  req_tgl,
    input  xcmd_t cmd,
    output logic  ack_tgl,
    output logic  per_en,
    output logic  per_srst
);
    logic req_s, req_q, req_edge;

    ctrl_sync #(.STAGES(SYNC_STAGES)) i_req_sync (
        .clk (clk),
        .rst (rst),
        .d   (req_tgl),
        .q   (req_s)
    );

    assign req_edge = req_s ^ req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q    <= 1'b0;
            ack_tgl  <= 1'b0;
            per_en   <= 1'b0;
            per_srst <= 1'b0;
        end else begin
            req_q    <= req_s;
            per_srst <= 1'b0;
            if (req_edge) begin
                ack_tgl <= ~ack_tgl;
                if (cmd.srst) begin
                    per_en   <= 1'b0;
                    per_srst <= 1'b1;
                end else begin
                    per_en <= cmd.en;
                end
            end
        end
    end

    // R8: reset pulse lasts one cycle
    a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
        per_srst |=> !per_srst);

    // R8: enable is low whenever the reset pulse is
    a_r8_disable: assert property (@(posedge clk) disable iff (rst)
        per_srst |-> !per_en);
endmodule

// File: rtl/ctrl_reg_xdom.sv
module ctrl_reg_xdom
    import ctrl_reg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              bus_clk,
    input  logic              bus_rst,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic              en_busy,
    output logic [CFG_W-1:0]  cfg_o,
    input  logic              per_clk,
    input  logic              per_rst,
    output logic              per_en,
    output logic              per_srst
);
    cfg_t  cfg;
    xcmd_t cmd;
    logic  en, srst_pend, en_wr, srst_wr, srst_done;
    logic  req_tgl, ack_tgl;

    ctrl_reg_file i_regs (
        .clk       (bus_clk),
        .rst       (bus_rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .srst_done (srst_done),
        .cfg       (cfg),
        .en        (en),
        .srst_pend (srst_pend),
        .en_wr     (en_wr),
        .srst_wr   (srst_wr)
    );

    ctrl_xfer_src #(.SYNC_STAGES(SYNC_STAGES)) i_src (
        .clk       (bus_clk),
        .rst       (bus_rst),
        .en_wr     (en_wr),
        .srst_wr   (srst_wr),
        .en_val    (en),
        .ack_tgl   (ack_tgl),
        .req_tgl   (req_tgl),
        .cmd       (cmd),
        .en_busy   (en_busy),
        .srst_done (srst_done)
    );

    ctrl_xfer_dst #(.SYNC_STAGES(SYNC_STAGES)) i_dst (
        .clk      (per_clk),
        .rst      (per_rst),
        .req_tgl  (req_tgl),
        .cmd      (cmd),
        .ack_tgl  (ack_tgl),
        .per_en   (per_en),
        .per_srst (per_srst)
    );

    assign rd_data = word_of(cfg, en, srst_pend);
    assign cfg_o   = cfg;
endmodule

// File: tb/test_ctrl_reg_xdom.sv
`timescale 1ns/1ps
module test_ctrl_reg_xdom;
    localparam int NS = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        en_busy;
    logic [18:0] cfg_o;
    logic        per_en, per_srst;

    always #4 clk = ~clk;

    ctrl_reg_xdom i_ctrl_reg_xdom (
        .bus_clk  (clk),
        .bus_rst  (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .en_busy  (en_busy),
        .cfg_o    (cfg_o),
        .per_clk  (clk),
        .per_rst  (rst),
        .per_en   (per_en),
        .per_srst (per_srst)
    );

    int    vectors = 0;
    int    miscomp = 0;
    int    cyc = 0;
    bit    primed = 0;
    string req_tag = "R1";

    // Behavioural model state
    logic [18:0] m_cfg;
    logic m_en, m_spend, m_srstq, m_dirty, m_infl, m_csrst, m_cen, m_pen, m_psrst;
    int   m_t;

    function automatic logic [31:0] exp_rd();
        return {9'b0, m_cfg, 2'b00, m_en, m_spend};
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscomp++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req_tag, what, act, exp, cyc);
        end
    endtask

    task automatic compare_all();
        chk("rd_data", rd_data, exp_rd());
        chk("cfg_o", {13'b0, cfg_o}, {13'b0, m_cfg});
        chk("en_busy", {31'b0, en_busy}, {31'b0, m_dirty | (m_infl & ~m_csrst)});
        chk("per_en", {31'b0, per_en}, {31'b0, m_pen});
        chk("per_srst", {31'b0, per_srst}, {31'b0, m_psrst});
    endtask

    task automatic model_edge(input logic r, input logic w, input logic [31:0] d);
        logic pre_spend, pre_en;
        if (r) begin
            m_cfg = '0; m_en = 0; m_spend = 0; m_srstq = 0; m_dirty = 0;
            m_infl = 0; m_csrst = 0; m_cen = 0; m_pen = 0; m_psrst = 0; m_t = 0;
            return;
        end
        m_psrst   = 0;
        pre_spend = m_spend;
        pre_en    = m_en;
        if (m_infl) begin
            m_t++;
            if (m_t == NS + 1) begin
                if (m_csrst) begin m_pen = 0; m_psrst = 1; end
                else m_pen = m_cen;
            end
            if (m_t == 2 * NS + 2) begin
                m_infl = 0;
                if (m_csrst) m_spend = 0;
            end
        end else if (m_srstq) begin
            m_infl = 1; m_t = 0; m_csrst = 1; m_cen = 0; m_srstq = 0;
        end else if (m_dirty) begin
            m_infl = 1; m_t = 0; m_csrst = 0; m_cen = pre_en; m_dirty = 0;
        end
        if (w && !pre_spend) begin
            if (d[0]) begin
                m_cfg = '0; m_en = 0; m_spend = 1; m_srstq = 1; m_dirty = 0;
            end else begin
                m_en = d[1];
                if (!pre_en) m_cfg = d[22:4];
                m_dirty = 1;
            end
        end
    endtask

    task automatic step(input logic r, input logic w, input logic [31:0] d);
        @(negedge clk);
        if (primed) compare_all();
        rst = r; wr_en = w; wr_data = d;
        @(posedge clk);
        model_edge(r, w, d);
        primed = 1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 32'h0);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            miscomp++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        req_tag = "R1";
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 32'h0);
        idle(3);

        // R2: full configuration write while disabled, unused bits set too
        req_tag = "R2";
        step(1'b0, 1'b1, 32'hFFFF_FFFC);
        idle(9);
        step(1'b0, 1'b1, 32'h0055_AA30);
        idle(9);

        // R4, R5: enable together with new fields, then watch latency
        req_tag = "R5";
        step(1'b0, 1'b1, 32'h0012_3452);
        idle(10);

        // R3: protected write (and enable clear) while enabled
        req_tag = "R3";
        step(1'b0, 1'b1, 32'h007F_FFF2);
        idle(9);
        step(1'b0, 1'b1, 32'h0000_0010);
        idle(10);

        // R4: fields accepted again once disabled
        req_tag = "R4";
        step(1'b0, 1'b1, 32'h0033_3330);
        idle(9);

        // R10: back-to-back enable writes queued behind a transfer
        req_tag = "R10";
        step(1'b0, 1'b1, 32'h0000_0002);
        step(1'b0, 1'b1, 32'h0000_0000);
        idle(2);
        step(1'b0, 1'b1, 32'h0000_0002);
        idle(20);

        // R6, R7, R8: software reset while enabled, other bits discarded
        req_tag = "R6";
        step(1'b0, 1'b1, 32'hFFFF_FFFF);
        req_tag = "R9";
        step(1'b0, 1'b1, 32'h0044_4442);
        step(1'b0, 1'b1, 32'h0000_0003);
        req_tag = "R7";
        idle(12);

        // R8: reset queued behind an in-flight enable transfer
        req_tag = "R8";
        step(1'b0, 1'b1, 32'h0000_0152);
        step(1'b0, 1'b1, 32'h0000_0001);
        idle(20);

        // R4: register usable again after reset
        req_tag = "R4";
        step(1'b0, 1'b1, 32'h0000_0022);
        idle(10);

        // R1: reset in mid-operation
        req_tag = "R1";
        step(1'b0, 1'b1, 32'h0000_0000);
        step(1'b1, 1'b0, 32'h0);
        idle(6);
        finish_run();
    end
endmodule